// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address. It walks a three-level radix page table that is held in memory. A walk begins with a start pulse that carries the virtual address, the byte address of the root table and an incoming global flag. The walker then fetches one 64-bit page table entry per level over a valid/ready memory port. Only one read is ever outstanding.

Each fetched entry is classified as one of three kinds:
- a pointer to the next table,
- a leaf mapping,
- an invalid entry.

A pointer sends the walk one level down. A leaf ends the walk. Leaves found above level 0 map large pages, so the walker checks their alignment and merges the untranslated virtual page bits into the physical page number. Permission rules are evaluated outside the block and arrive as a single pass/fail bit alongside the leaf response.

When the walk completes, the block pulses `done_o` for one cycle. It then presents either the physical address, the leaf entry, the entry's address, the leaf level and the accumulated global flag, or a fault code. All of these values are held until the next walk completes.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `mem_req_valid_o` and `done_o` are all 0.
- R2: A start pulse is taken only when `busy_o` is 0. A start pulse seen while busy is ignored. An accepted start latches the virtual address, the root and `global_i`, and raises `busy_o`. The first read goes to root + 8·VA[38:30], which is level 2.
- R3: A memory request keeps its valid and its address stable until ready is seen. No new request is issued until the response to the previous one has arrived.
- R4: A pointer entry has bit0 (valid) = 1 and bits 1 (read), 2 (write) and 3 (execute) all 0. A pointer at level L > 0 makes the next read go to (entry[53:10] << 12) + 8·VA[20+9(L-1) : 12+9(L-1)], at level L-1.
- R5: A response with the error flag set ends the walk with fault code 1.
- R6: An entry with bit0 = 0, or with bit2 = 1 and bit1 = 0, ends the walk with fault code 2.
- R7: A pointer entry at level 0 ends the walk with fault code 2.
- R8: A leaf whose permission input is 0 ends the walk with fault code 4. This check takes priority over the alignment check.
- R9: A leaf at level L > 0 whose physical page number has any of its low 9·L bits set ends the walk with fault code 3.
- R10: On success, the physical address is the page number (entry[53:10]) with its low 9·L bits replaced by VA[12+9L-1:12], shifted left by 12 and combined with the offset VA[11:0].
- R11: The global output is `global_i` ORed with bit5 of every entry fetched in the walk.
- R12: On completion, `done_o` pulses for exactly one cycle, in the cycle after the final response, with `busy_o` already 0. On success, fault code 0 is returned together with the leaf entry, its address and its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a walk |
| va_i | input | 39 | Virtual address |
| root_i | input | 56 | Root table byte address |
| global_i | input | 1 | Incoming global flag |
| perm_ok_i | input | 1 | External permission verdict for a leaf, sampled with the response |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Entry read request accepted |
| mem_req_addr_o | output | 56 | Entry byte address |
| mem_rsp_valid_i | input | 1 | Entry response valid |
| mem_rsp_err_i | input | 1 | Entry read failed |
| mem_rsp_data_i | input | 64 | Entry data |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Last walk faulted |
| fault_code_o | output | 3 | 0 ok, 1 access, 2 invalid entry, 3 misaligned, 4 permission |
| pa_o | output | 56 | Translated physical address |
| pte_o | output | 64 | Last entry fetched |
| pte_addr_o | output | 56 | Address of that entry |
| level_o | output | 2 | Level of that entry |
| global_o | output | 1 | Accumulated global flag |

## Verification
The bench runs walks that end at every level: a 4 KiB leaf, a 2 MiB page and a 1 GiB page. If the superpage merge were wrong, the low physical page bits would come out as the entry's bits rather than the virtual address bits. It covers an aligned large page and a misaligned one. It also sends a misaligned leaf whose permission is denied; a design with the checks in the wrong order would report code 3 for it instead of 4. Further cases cover:
- an invalid entry, including the write-without-read encoding;
- a pointer at level 0;
- a memory error in the middle of a walk;
- global bits set on the incoming flag, on an intermediate entry and on the leaf, which catches a design that keeps only the leaf's bit;
- a stalled request with a stray start pulse, which exposes a walker that restarts or lets its address drift.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ACCESS   = 3'd1,
    FLT_INVALID  = 3'd2,
    FLT_MISALIGN = 3'd3,
    FLT_PERM     = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } walk_state_e;

  localparam int FLG_V = 0;
  localparam int FLG_R = 1;
  localparam int FLG_W = 2;
  localparam int FLG_X = 3;
  localparam int FLG_G = 5;
endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int PTE_W   = 64,
  parameter int PPN_W   = 44,
  parameter int PPN_LSB = 10
) (
  input  logic [PTE_W-1:0] pte_i,
  output logic             invalid_o,
  output logic             pointer_o,
  output logic             global_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic v, r, w, x;
  logic unused_dec;

  assign v = pte_i[FLG_V];
  assign r = pte_i[FLG_R];
  assign w = pte_i[FLG_W];
  assign x = pte_i[FLG_X];

  assign invalid_o = !v || (w && !r);
  assign pointer_o = v && !r && !w && !x;
  assign global_o  = pte_i[FLG_G];
  assign ppn_o     = pte_i[PPN_LSB +: PPN_W];

  assign unused_dec = ^{pte_i[PTE_W-1:PPN_LSB+PPN_W], pte_i[PPN_LSB-1:FLG_G+1], pte_i[4]};
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W      = 39,
  parameter int PA_W      = 56,
  parameter int LEVELS    = 3,
  parameter int VPN_W     = 9,
  parameter int PAGE_BITS = 12,
  parameter int PTE_LOG   = 3,
  parameter int LVL_W     = 2
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [VPN_W-1:0] vpn_arr [LEVELS];
  logic [VPN_W-1:0] vpn_sel;
  logic             unused_ofs;

  for (genvar l = 0; l < LEVELS; l++) begin : g_vpn
    assign vpn_arr[l] = va_i[PAGE_BITS + l*VPN_W +: VPN_W];
  end

  always_comb begin
    vpn_sel = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level_i == LVL_W'(l)) vpn_sel = vpn_arr[l];
    end
  end

  assign addr_o     = base_i + (PA_W'(vpn_sel) << PTE_LOG);
  assign unused_ofs = ^va_i[PAGE_BITS-1:0];
endmodule

// File: rtl/ptw_leaf_pa.sv
module ptw_leaf_pa #(
  parameter  int VA_W      = 39,
  parameter  int PA_W      = 56,
  parameter  int LVL_W     = 2,
  parameter  int VPN_W     = 9,
  parameter  int PAGE_BITS = 12,
  localparam int PPN_W     = PA_W - PAGE_BITS,
  localparam int VPNS_W    = VA_W - PAGE_BITS
) (
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             misaligned_o,
  output logic [PA_W-1:0]  pa_o
);
  logic [PPN_W-1:0] low_mask;
  logic [PPN_W-1:0] vpns;

  // bits below the leaf level come from the VA
  assign low_mask     = ~({PPN_W{1'b1}} << (int'(level_i) * VPN_W));
  assign vpns         = PPN_W'(va_i[VA_W-1:PAGE_BITS]);
  assign misaligned_o = |(ppn_i & low_mask);
  assign pa_o         = {ppn_i | (vpns & low_mask), va_i[PAGE_BITS-1:0]};

  if (VPNS_W > PPN_W) begin : g_bad_width
    initial $error("virtual page field wider than physical page number");
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter  int VA_W      = 39,
  parameter  int PA_W      = 56,
  parameter  int PTE_W     = 64,
  parameter  int LEVELS    = 3,
  parameter  int VPN_W     = 9,
  parameter  int PAGE_BITS = 12,
  parameter  int PTE_LOG   = 3,
  parameter  int PPN_LSB   = 10,
  localparam int PPN_W     = PA_W - PAGE_BITS,
  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [PA_W-1:0]  root_i,
  input  logic             global_i,
  input  logic             perm_ok_i,
  output logic             busy_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic             mem_rsp_err_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [2:0]       fault_code_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [PTE_W-1:0] pte_o,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [LVL_W-1:0] level_o,
  output logic             global_o
);
  walk_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             glob_q;

  logic             done_q;
  fault_e           fault_q;
  logic [PA_W-1:0]  pa_q;
  logic [PTE_W-1:0] pte_q;
  logic [PA_W-1:0]  pte_addr_q;
  logic [LVL_W-1:0] lvl_out_q;
  logic             glob_out_q;

  logic             dec_invalid, dec_pointer, dec_g;
  logic [PPN_W-1:0] dec_ppn;
  logic [PA_W-1:0]  req_addr;
  logic             leaf_misaligned;
  logic [PA_W-1:0]  leaf_pa;

  logic             walk_on;
  fault_e           fault_nxt;
  logic             glob_acc;

  ptw_pte_decode #(
    .PTE_W  (PTE_W),
    .PPN_W  (PPN_W),
    .PPN_LSB(PPN_LSB)
  ) u_dec (
    .pte_i    (mem_rsp_data_i),
    .invalid_o(dec_invalid),
    .pointer_o(dec_pointer),
    .global_o (dec_g),
    .ppn_o    (dec_ppn)
  );

  ptw_addr_gen #(
    .VA_W     (VA_W),
    .PA_W     (PA_W),
    .LEVELS   (LEVELS),
    .VPN_W    (VPN_W),
    .PAGE_BITS(PAGE_BITS),
    .PTE_LOG  (PTE_LOG),
    .LVL_W    (LVL_W)
  ) u_addr (
    .base_i (base_q),
    .va_i   (va_q),
    .level_i(lvl_q),
    .addr_o (req_addr)
  );

  ptw_leaf_pa #(
    .VA_W     (VA_W),
    .PA_W     (PA_W),
    .LVL_W    (LVL_W),
    .VPN_W    (VPN_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_leaf (
    .ppn_i       (dec_ppn),
    .va_i        (va_q),
    .level_i     (lvl_q),
    .misaligned_o(leaf_misaligned),
    .pa_o        (leaf_pa)
  );

  // fault priority: bus error, invalid, pointer at bottom, permission, alignment
  always_comb begin
    walk_on   = 1'b0;
    fault_nxt = FLT_NONE;
    if (mem_rsp_err_i)                 fault_nxt = FLT_ACCESS;
    else if (dec_invalid)              fault_nxt = FLT_INVALID;
    else if (dec_pointer) begin
      if (lvl_q == '0)                 fault_nxt = FLT_INVALID;
      else                             walk_on   = 1'b1;
    end
    else if (!perm_ok_i)               fault_nxt = FLT_PERM;
    else if (leaf_misaligned)          fault_nxt = FLT_MISALIGN;
  end

  assign glob_acc = glob_q | (!mem_rsp_err_i && dec_g);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      base_q     <= '0;
      lvl_q      <= '0;
      glob_q     <= 1'b0;
      done_q     <= 1'b0;
      fault_q    <= FLT_NONE;
      pa_q       <= '0;
      pte_q      <= '0;
      pte_addr_q <= '0;
      lvl_out_q  <= '0;
      glob_out_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            va_q    <= va_i;
            base_q  <= root_i;
            lvl_q   <= LVL_W'(LEVELS - 1);
            glob_q  <= global_i;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready_i) state_q <= ST_RSP;
        end
        ST_RSP: begin
          if (mem_rsp_valid_i) begin
            glob_q <= glob_acc;
            if (walk_on) begin
              base_q  <= {dec_ppn, {PAGE_BITS{1'b0}}};
              lvl_q   <= lvl_q - 1'b1;
              state_q <= ST_REQ;
            end else begin
              state_q    <= ST_IDLE;
              done_q     <= 1'b1;
              fault_q    <= fault_nxt;
              pa_q       <= leaf_pa;
              pte_q      <= mem_rsp_data_i;
              pte_addr_q <= req_addr;
              lvl_out_q  <= lvl_q;
              glob_out_q <= glob_acc;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = req_addr;
  assign done_o          = done_q;
  assign fault_o         = (fault_q != FLT_NONE);
  assign fault_code_o    = fault_q;
  assign pa_o            = pa_q;
  assign pte_o           = pte_q;
  assign pte_addr_o      = pte_addr_q;
  assign level_o         = lvl_out_q;
  assign global_o        = glob_out_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter  int PA_W   = 56,
  parameter  int LEVELS = 3,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic             mem_rsp_valid_i,
  input logic             mem_rsp_err_i,
  input logic             done_o,
  input logic [2:0]       fault_code_o,
  input logic [LVL_W-1:0] level_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !mem_req_valid_o && !done_o);

  assert_start_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o);

  assert_idle_no_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_valid_o);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_access_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_req_valid_o && mem_rsp_valid_i && mem_rsp_err_i
      |=> done_o && fault_code_o == 3'd1);

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_level_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> int'(level_o) <= LEVELS - 1);
endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W), .LEVELS(LEVELS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .busy_o         (busy_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .mem_rsp_err_i  (mem_rsp_err_i),
  .done_o         (done_o),
  .fault_code_o   (fault_code_o),
  .level_o        (level_o)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int VA_W = 39;
  localparam int PA_W = 56;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [VA_W-1:0] va_i = '0;
  logic [PA_W-1:0] root_i = '0;
  logic            global_i = 1'b0;
  logic            perm_ok_i = 1'b0;
  logic            busy_o;
  logic            mem_req_valid_o;
  logic            mem_req_ready_i = 1'b0;
  logic [PA_W-1:0] mem_req_addr_o;
  logic            mem_rsp_valid_i = 1'b0;
  logic            mem_rsp_err_i = 1'b0;
  logic [63:0]     mem_rsp_data_i = '0;
  logic            done_o;
  logic            fault_o;
  logic [2:0]      fault_code_o;
  logic [PA_W-1:0] pa_o;
  logic [63:0]     pte_o;
  logic [PA_W-1:0] pte_addr_o;
  logic [1:0]      level_o;
  logic            global_o;

  pt_walker dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [2:0]      code;
    logic [PA_W-1:0] pa;
    logic [63:0]     pte;
    logic [PA_W-1:0] paddr;
    int              lvl;
    bit              glob;
    bit              full;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int checks = 0;
  int errors = 0;
  logic [63:0] ptes [3];
  bit sim_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!sim_done) begin
      sim_done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [7:0] flags);
    return ({20'b0, ppn} << 10) | {56'b0, flags};
  endfunction

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) chk(0, "R12 unexpected done", 1, 0);
      else begin
        mon_e = exp_q.pop_front();
        chk(!busy_o, {"R12 busy low at done ", mon_e.tag}, 64'(busy_o), 0);
        chk(fault_code_o == mon_e.code, {"fault code ", mon_e.tag}, 64'(fault_code_o), 64'(mon_e.code));
        if (mon_e.full) begin
          chk(pa_o == mon_e.pa, {"R10 pa ", mon_e.tag}, 64'(pa_o), 64'(mon_e.pa));
          chk(pte_o == mon_e.pte, {"R12 pte ", mon_e.tag}, pte_o, mon_e.pte);
          chk(pte_addr_o == mon_e.paddr, {"R12 pte addr ", mon_e.tag}, 64'(pte_addr_o), 64'(mon_e.paddr));
          chk(int'(level_o) == mon_e.lvl, {"R12 level ", mon_e.tag}, 64'(level_o), 64'(mon_e.lvl));
          chk(global_o == mon_e.glob, {"R11 global ", mon_e.tag}, 64'(global_o), 64'(mon_e.glob));
        end
      end
    end
  end

  // driver + memory responder; pushes the expected result before the final response
  task automatic run_walk(input logic [VA_W-1:0] va, input logic [PA_W-1:0] root, input bit gin,
                          input int n, input bit err_last, input bit perm, input int stall,
                          input string tag);
    logic [PA_W-1:0] base, a;
    logic [63:0]     p;
    logic [43:0]     ppn, mask;
    int              lvl;
    bit              g, term;
    exp_t            e;
    @(negedge clk_i);
    start_i = 1; va_i = va; root_i = root; global_i = gin;
    @(negedge clk_i);
    start_i = 0;
    chk(busy_o, {"R2 busy after start ", tag}, 64'(busy_o), 1);
    base = root; lvl = 2; g = gin;
    for (int s = 0; s < n; s++) begin
      a = base + (PA_W'((va >> (12 + 9*lvl)) & 39'h1FF) << 3);
      while (!mem_req_valid_o) @(negedge clk_i);
      chk(mem_req_addr_o == a, {"R2/R4 read address ", tag}, 64'(mem_req_addr_o), 64'(a));
      for (int k = 0; k < stall; k++) begin
        if (k == 0 && s == 0) begin
          start_i = 1; va_i = ~va; root_i = ~root;
        end
        @(negedge clk_i);
        start_i = 0;
        chk(mem_req_valid_o && mem_req_addr_o == a, {"R3 R2 held request ", tag}, 64'(mem_req_addr_o), 64'(a));
      end
      mem_req_ready_i = 1;
      @(negedge clk_i);
      mem_req_ready_i = 0;
      @(negedge clk_i);
      chk(!mem_req_valid_o, {"R3 one outstanding ", tag}, 64'(mem_req_valid_o), 0);
      p = ptes[s];
      ppn = p[53:10];
      term = 1;
      e.code = 3'd0; e.pa = '0; e.pte = p; e.paddr = a; e.lvl = lvl; e.full = 0; e.tag = tag;
      if (s == n-1 && err_last) e.code = 3'd1;
      else begin
        g = g | p[5];
        if (!p[0] || (p[2] && !p[1])) e.code = 3'd2;
        else if (!p[1] && !p[2] && !p[3]) begin
          if (lvl == 0) e.code = 3'd2;
          else term = 0;
        end else begin
          mask = (44'h1 << (9*lvl)) - 44'h1;
          if (!perm) e.code = 3'd4;
          else if ((ppn & mask) != 0) e.code = 3'd3;
          else begin
            e.full = 1;
            e.pa = {ppn | ({17'b0, va[38:12]} & mask), va[11:0]};
          end
        end
      end
      e.glob = g;
      if (term) exp_q.push_back(e);
      mem_rsp_valid_i = 1; mem_rsp_data_i = p; mem_rsp_err_i = (s == n-1) && err_last;
      perm_ok_i = perm;
      @(negedge clk_i);
      mem_rsp_valid_i = 0; mem_rsp_err_i = 0;
      if (!term) begin
        base = {ppn, 12'b0};
        lvl--;
      end
    end
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    logic [VA_W-1:0] va;
    va = {9'h0A5, 9'h13C, 9'h07F, 12'hABC};
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !mem_req_valid_o && !done_o, "R1 reset state", {busy_o, mem_req_valid_o, done_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !mem_req_valid_o && !done_o, "R1 after reset", {busy_o, mem_req_valid_o, done_o}, 0);

    // R4 R10 R12: 4 KiB page through two pointers, with a stalled request
    ptes[0] = mk_pte(44'h100, 8'h01); ptes[1] = mk_pte(44'h200, 8'h01); ptes[2] = mk_pte(44'h12345, 8'hCF);
    run_walk(va, 56'h80_0000, 0, 3, 0, 1, 3, "R10 4k leaf");
    // R10: 1 GiB page
    ptes[0] = mk_pte(44'h40000, 8'h0F);
    run_walk(va, 56'h9000, 0, 1, 0, 1, 0, "R10 1g leaf");
    // R10: 2 MiB page
    ptes[0] = mk_pte(44'h300, 8'h01); ptes[1] = mk_pte(44'h3FE00, 8'h0B);
    run_walk(va, 56'h9000, 0, 2, 0, 1, 1, "R10 2m leaf");
    // R9: misaligned 2 MiB page
    ptes[1] = mk_pte(44'h3FE01, 8'h0B);
    run_walk(va, 56'h9000, 0, 2, 0, 1, 0, "R9 misaligned");
    // R8: permission before alignment
    run_walk(va, 56'h9000, 0, 2, 0, 0, 0, "R8 perm over misalign");
    ptes[0] = mk_pte(44'h100, 8'h01); ptes[1] = mk_pte(44'h200, 8'h01); ptes[2] = mk_pte(44'h777, 8'h0B);
    run_walk(va, 56'h80_0000, 0, 3, 0, 0, 0, "R8 perm denied");
    // execute-only leaf is a valid leaf
    ptes[2] = mk_pte(44'h777, 8'h09);
    run_walk(va, 56'h80_0000, 0, 3, 0, 1, 0, "R6 R10 execute-only leaf");
    // R5: bus error at level 1
    run_walk(va, 56'h80_0000, 0, 2, 1, 1, 0, "R5 access fault");
    // R6: invalid entries
    ptes[0] = 64'h0;
    run_walk(va, 56'h80_0000, 0, 1, 0, 1, 0, "R6 valid bit clear");
    ptes[0] = mk_pte(44'h100, 8'h01); ptes[1] = mk_pte(44'h555, 8'h05);
    run_walk(va, 56'h80_0000, 0, 2, 0, 1, 0, "R6 write without read");
    // R7: pointer at level 0
    ptes[1] = mk_pte(44'h200, 8'h01); ptes[2] = mk_pte(44'h300, 8'h01);
    run_walk(va, 56'h80_0000, 0, 3, 0, 1, 0, "R7 pointer at bottom");
    // R11: global accumulation
    ptes[0] = mk_pte(44'h100, 8'h01); ptes[1] = mk_pte(44'h200, 8'h21); ptes[2] = mk_pte(44'hABCDE, 8'hCF);
    run_walk({9'h1FF, 9'h000, 9'h1FF, 12'h001}, 56'h1000, 0, 3, 0, 1, 0, "R11 middle G");
    ptes[1] = mk_pte(44'h200, 8'h01);
    run_walk(va, 56'h1000, 1, 3, 0, 1, 0, "R11 incoming G");
    ptes[2] = mk_pte(44'hABCDE, 8'hEF);
    run_walk(va, 56'h1000, 0, 3, 0, 1, 0, "R11 leaf G");

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R12 all walks completed", 64'(exp_q.size()), 0);
    finish_sim();
  end
endmodule